// File: doc/BRIEF.md
# Video Output Formatter

The formatter sits at the end of a video scaling pipeline. It takes one scaled pixel per accepted transfer (a luma byte and a chroma byte, with line framing flags), turns it into a byte stream in one of three packing formats, gathers the bytes into 36-bit words (a 32-bit data field plus a small sideband of byte count and line markers) and keeps them in a FIFO. That FIFO holds 64 pixels of 4:2:2 data. On the far side the bytes leave on an 8-bit or a 16-bit port. A transfer happens only when the receiver raises its enable, so the receiver may read in bursts or with gaps.

Line boundaries are reported in one of two ways. In pin mode, two strobes mark the output beats that carry the first and the last byte of a line. In embedded mode, a four-byte timing code is placed in the stream before and after each line, and video bytes that could be mistaken for a code are clipped. The configuration inputs are static and may only change while the block is idle.

The input side runs a small state machine. S_ACCEPT takes pixels and packs their bytes. When a line ends it moves to S_FLUSH. S_FLUSH writes any partial word: it goes straight on if no bytes remain, and it waits while the FIFO is full. S_FLUSH then moves to S_TRAIL in embedded mode, or back to S_ACCEPT in pin mode. S_TRAIL writes the end-of-line code when the FIFO has room and then returns to S_ACCEPT. The start-of-line code is written from S_ACCEPT, in the same cycle that accepts the line's first pixel.

Top module: `video_out_formatter`

## Requirements
- R1: After reset, out_valid is 0, out_sol and out_eol are 0, and in_req is 1.
- R2: With cfg_fmt=0 (4:2:2) each pixel adds its chroma byte and then its luma byte, so an 8-bit port carries Cb, Y, Cr, Y when chroma alternates Cb, Cr.
- R3: With cfg_fmt=1 (4:1:1), pixel positions are counted modulo 4 from the pixel carrying in_sol. Pixels at positions 0 and 2 add chroma and then luma. Pixels at positions 1 and 3 add only luma, and their in_c is ignored. The result is the order Cb Y0 Y1 Cr Y2 Y3.
- R4: With cfg_fmt=2 or 3 (luma only, also used for raw data) each pixel adds only its luma byte, and in_c has no effect on the output.
- R5: With cfg_wide=0, each beat puts one byte on out_data[7:0] and holds out_data[15:8] at 0. With cfg_wide=1, each beat carries two stream bytes: the earlier byte on out_data[15:8] and the later byte on out_data[7:0]. In 4:2:2 this puts chroma on the high lane and luma on the low lane.
- R6: A pixel with in_eol makes all of its line's bytes leave the FIFO without waiting for later pixels. In wide mode, a line with an odd byte count is padded with the byte 0x10 on the low lane of its last beat.
- R7: With cfg_embed=1, each line is preceded by the bytes FF 00 00 S and followed by FF 00 00 E. Each status byte has the bit layout {1, F, V, H, V^H, F^H, F^V, F^V^H}. H is 0 in S and 1 in E. F and V are in_field and in_vblank as seen with the line's first pixel.
- R8: With cfg_embed=1, video byte 0x00 leaves as 0x01 and 0xFF leaves as 0xFE. With cfg_embed=0, all video bytes pass unchanged.
- R9: With cfg_embed=0, out_sol is high on the beat carrying the first byte of a line and out_eol on the beat carrying the last byte. With cfg_embed=1 both stay 0.
- R10: in_req is low whenever the FIFO has no free word. With the output enable held low, exactly 64 pixels of a 4:2:2 line are accepted before in_req stays low.
- R11: A beat is consumed only in a cycle where out_valid and out_en are both high. While out_en is low, out_valid stays high and out_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Packing format: 0 = 4:2:2, 1 = 4:1:1, 2/3 = luma only |
| cfg_wide | input | 1 | 1 = 16-bit output, 0 = 8-bit output |
| cfg_embed | input | 1 | 1 = timing codes in the stream, 0 = strobe pins |
| in_valid | input | 1 | Input pixel present |
| in_req | output | 1 | Formatter can take a pixel this cycle |
| in_y | input | 8 | Luma (or raw) byte |
| in_c | input | 8 | Chroma byte (Cb or Cr) |
| in_sol | input | 1 | Pixel is the first of a line |
| in_eol | input | 1 | Pixel is the last of a line |
| in_field | input | 1 | Field bit for the line, taken with the first pixel |
| in_vblank | input | 1 | Vertical-blank bit for the line, taken with the first pixel |
| out_en | input | 1 | Receiver takes the current beat |
| out_valid | output | 1 | A complete beat is on out_data |
| out_data | output | 16 | Output beat |
| out_sol | output | 1 | Beat carries the first byte of a line (pin mode) |
| out_eol | output | 1 | Beat carries the last byte of a line (pin mode) |

## Verification
The hardest state to reach is a full FIFO with the input side blocked. This needs a line longer than the buffer, while the receiver takes nothing. The bench gets there by holding out_en low and presenting 4:2:2 pixels of one open line without a break. It counts the accepted transfers until in_req has stayed low for several cycles. It then releases the output, closes the line and confirms that every buffered byte arrives in order. The short lines are also chosen so that the flush state sees partial words of one, two and three bytes, and so that wide-mode padding occurs.

// File: rtl/vof_pkg.sv
package vof_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_B   = 4;
    localparam int WORD_W   = BYTE_W * WORD_B;
    localparam logic [7:0] FILL_BYTE = 8'h10;

    typedef enum logic [1:0] {
        FMT_422  = 2'd0,
        FMT_411  = 2'd1,
        FMT_Y    = 2'd2,
        FMT_YRAW = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        S_ACCEPT = 2'd0,
        S_FLUSH  = 2'd1,
        S_TRAIL  = 2'd2
    } pk_state_e;

    // one FIFO entry: data bytes (byte 0 leaves first) plus sideband
    typedef struct packed {
        logic              sol;     // byte 0 opens a line
        logic              eol;     // last valid byte closes a line
        logic [1:0]        cnt_m1;  // valid bytes minus one
        logic [WORD_W-1:0] data;
    } fword_t;

    function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] protect_byte(input logic [7:0] b, input logic en);
        logic [7:0] r;
        r = b;
        if (en && b == 8'h00) r = 8'h01;
        if (en && b == 8'hFF) r = 8'hFE;
        return r;
    endfunction

endpackage

// File: rtl/vof_fifo.sv
module vof_fifo #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             has_room
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    count_q;

    assign empty    = (count_q == '0);
    assign has_room = (count_q != FULL);
    assign rdata    = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q != FULL)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count_q != '0)); // R11

endmodule

// File: rtl/vof_pack.sv
module vof_pack
    import vof_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_fmt,
    input  logic       cfg_wide,
    input  logic       cfg_embed,
    input  logic       in_valid,
    output logic       in_req,
    input  logic [7:0] in_y,
    input  logic [7:0] in_c,
    input  logic       in_sol,
    input  logic       in_eol,
    input  logic       in_field,
    input  logic       in_vblank,
    input  logic       fifo_room,
    output logic       wr_en,
    output fword_t     wr_word
);

    pk_state_e        state_q, state_d;
    logic [3:0][7:0]  acc_q, acc_d;
    logic [2:0]       cnt_q, cnt_d;
    logic             sol_q, sol_d;
    logic [1:0]       phase_q, phase_d;
    logic             fld_q, fld_d, vbl_q, vbl_d;

    logic             take;
    logic [1:0]       phase;
    logic [7:0]       yb, cb, b0, b1;
    logic [2:0]       nb, sum;
    logic [4:0][7:0]  tmp;
    logic [3:0][7:0]  padw;
    logic [2:0]       fcnt;
    logic             sol_now;
    fmt_e             fmt;

    assign fmt    = fmt_e'(cfg_fmt);
    assign in_req = (state_q == S_ACCEPT) && fifo_room;
    assign take   = in_req && in_valid;
    assign phase  = in_sol ? 2'd0 : phase_q;
    assign yb     = protect_byte(in_y, cfg_embed);
    assign cb     = protect_byte(in_c, cfg_embed);

    // bytes contributed by the current pixel
    always_comb begin
        b0 = yb;
        b1 = yb;
        nb = 3'd1;
        unique case (fmt)
            FMT_422: begin
                b0 = cb;
                nb = 3'd2;
            end
            FMT_411: begin
                if (!phase[0]) begin
                    b0 = cb;
                    nb = 3'd2;
                end
            end
            default: nb = 3'd1;
        endcase
    end

    // merge new bytes behind the held ones
    always_comb begin
        tmp = {8'h00, acc_q};
        tmp[cnt_q] = b0;
        if (nb == 3'd2) tmp[3'(cnt_q + 3'd1)] = b1;
        sum = cnt_q + nb;
    end

    // partial word at line end, padded to a byte pair in wide mode
    always_comb begin
        padw = acc_q;
        fcnt = cnt_q;
        if (cfg_wide && cnt_q[0]) begin
            padw[cnt_q[1:0]] = FILL_BYTE;
            fcnt = cnt_q + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ACCEPT;
            acc_q   <= '0;
            cnt_q   <= '0;
            sol_q   <= 1'b0;
            phase_q <= '0;
            fld_q   <= 1'b0;
            vbl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            cnt_q   <= cnt_d;
            sol_q   <= sol_d;
            phase_q <= phase_d;
            fld_q   <= fld_d;
            vbl_q   <= vbl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        cnt_d   = cnt_q;
        sol_d   = sol_q;
        phase_d = phase_q;
        fld_d   = fld_q;
        vbl_d   = vbl_q;
        wr_en   = 1'b0;
        wr_word = '0;
        sol_now = sol_q | in_sol;
        unique case (state_q)
            S_ACCEPT: begin
                if (take) begin
                    phase_d = phase + 2'd1;
                    if (in_sol) begin
                        fld_d = in_field;
                        vbl_d = in_vblank;
                    end
                    if (sum >= 3'd4) begin
                        wr_en          = 1'b1;
                        wr_word.sol    = sol_now;
                        wr_word.eol    = in_eol && (sum == 3'd4);
                        wr_word.cnt_m1 = 2'd3;
                        wr_word.data   = tmp[3:0];
                        acc_d          = {24'h0, tmp[4]};
                        cnt_d          = sum - 3'd4;
                        sol_d          = 1'b0;
                    end else begin
                        acc_d = tmp[3:0];
                        cnt_d = sum;
                        sol_d = sol_now;
                    end
                    if (cfg_embed && in_sol) begin
                        wr_en          = 1'b1;
                        wr_word.sol    = 1'b0;
                        wr_word.eol    = 1'b0;
                        wr_word.cnt_m1 = 2'd3;
                        wr_word.data   = {status_byte(in_field, in_vblank, 1'b0), 8'h00, 8'h00, 8'hFF};
                    end
                    if (in_eol) state_d = S_FLUSH;
                end
            end
            S_FLUSH: begin
                if (cnt_q == 3'd0) begin
                    state_d = cfg_embed ? S_TRAIL : S_ACCEPT;
                end else if (fifo_room) begin
                    wr_en          = 1'b1;
                    wr_word.sol    = sol_q;
                    wr_word.eol    = 1'b1;
                    wr_word.cnt_m1 = 2'(fcnt - 3'd1);
                    wr_word.data   = padw;
                    acc_d          = '0;
                    cnt_d          = '0;
                    sol_d          = 1'b0;
                    state_d        = cfg_embed ? S_TRAIL : S_ACCEPT;
                end
            end
            S_TRAIL: begin
                if (fifo_room) begin
                    wr_en          = 1'b1;
                    wr_word.cnt_m1 = 2'd3;
                    wr_word.data   = {status_byte(fld_q, vbl_q, 1'b1), 8'h00, 8'h00, 8'hFF};
                    state_d        = S_ACCEPT;
                end
            end
            default: state_d = S_ACCEPT;
        endcase
    end

    AST_TRAIL_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRAIL) |-> (cnt_q == 3'd0)); // R7
    AST_FLUSH_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH && cnt_q == 3'd0) |=> (state_q != S_FLUSH)); // R6
    AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_ACCEPT) |-> !take); // R10

endmodule

// File: rtl/vof_unpack.sv
module vof_unpack
    import vof_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wide,
    input  logic        cfg_embed,
    input  logic        empty,
    input  fword_t      head,
    output logic        pop,
    input  logic        out_en,
    output logic        out_valid,
    output logic [15:0] out_data,
    output logic        out_sol,
    output logic        out_eol
);

    logic [1:0]      ptr_q;
    logic [3:0][7:0] hb;
    logic [7:0]      byte_a, byte_b;
    logic [2:0]      cnt, step, next_ptr;
    logic            last, fire;

    assign hb        = head.data;
    assign byte_a    = hb[ptr_q];
    assign byte_b    = hb[2'(ptr_q + 2'd1)];
    assign cnt       = {1'b0, head.cnt_m1} + 3'd1;
    assign step      = cfg_wide ? 3'd2 : 3'd1;
    assign next_ptr  = {1'b0, ptr_q} + step;
    assign last      = (next_ptr >= cnt);
    assign out_valid = !empty;
    assign fire      = out_valid && out_en;
    assign pop       = fire && last;
    assign out_data  = cfg_wide ? {byte_a, byte_b} : {8'h00, byte_a};
    assign out_sol   = out_valid && !cfg_embed && head.sol && (ptr_q == 2'd0);
    assign out_eol   = out_valid && !cfg_embed && head.eol && last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fire) begin
            ptr_q <= last ? 2'd0 : next_ptr[1:0];
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_en) |=> (out_valid && $stable(out_data))); // R11
    AST_WIDE_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_wide) |-> (head.cnt_m1[0] && !ptr_q[0])); // R6

endmodule

// File: rtl/video_out_formatter.sv
module video_out_formatter
    import vof_pkg::*;
#(
    parameter int PIX_CAP = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_fmt,
    input  logic        cfg_wide,
    input  logic        cfg_embed,
    input  logic        in_valid,
    output logic        in_req,
    input  logic [7:0]  in_y,
    input  logic [7:0]  in_c,
    input  logic        in_sol,
    input  logic        in_eol,
    input  logic        in_field,
    input  logic        in_vblank,
    input  logic        out_en,
    output logic        out_valid,
    output logic [15:0] out_data,
    output logic        out_sol,
    output logic        out_eol
);

    // 4:2:2 needs two bytes per pixel
    localparam int FIFO_WORDS = (PIX_CAP * 2) / WORD_B;
    localparam int ENTRY_W    = $bits(fword_t);

    logic   wr_en, rd_pop, f_empty, f_room;
    fword_t wr_word, head;
    logic [ENTRY_W-1:0] head_bits;

    assign head = fword_t'(head_bits);

    vof_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_fmt   (cfg_fmt),
        .cfg_wide  (cfg_wide),
        .cfg_embed (cfg_embed),
        .in_valid  (in_valid),
        .in_req    (in_req),
        .in_y      (in_y),
        .in_c      (in_c),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .in_field  (in_field),
        .in_vblank (in_vblank),
        .fifo_room (f_room),
        .wr_en     (wr_en),
        .wr_word   (wr_word)
    );

    vof_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (FIFO_WORDS)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en),
        .wdata    (wr_word),
        .pop      (rd_pop),
        .rdata    (head_bits),
        .empty    (f_empty),
        .has_room (f_room)
    );

    vof_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wide  (cfg_wide),
        .cfg_embed (cfg_embed),
        .empty     (f_empty),
        .head      (head),
        .pop       (rd_pop),
        .out_en    (out_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sol   (out_sol),
        .out_eol   (out_eol)
    );

    AST_PIN_STROBES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_embed |-> (!out_sol && !out_eol)); // R9

endmodule

// File: tb/video_out_formatter_tb_top.sv
module video_out_formatter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_fmt;
    logic        cfg_wide, cfg_embed;
    logic        in_valid, in_req, in_sol, in_eol, in_field, in_vblank;
    logic [7:0]  in_y, in_c;
    logic        out_en, out_valid, out_sol, out_eol;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    video_out_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wide(cfg_wide),
        .cfg_embed(cfg_embed), .in_valid(in_valid), .in_req(in_req),
        .in_y(in_y), .in_c(in_c), .in_sol(in_sol), .in_eol(in_eol),
        .in_field(in_field), .in_vblank(in_vblank), .out_en(out_en),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
        .out_eol(out_eol)
    );

    int total = 0, bad = 0;
    int cyc = 0, en_mode = 0, beat_n = 0;
    logic hi_nz;
    logic [7:0] got_q[$], exp_q[$];
    int sol_beat[$], eol_beat[$];

    // receiver: decides out_en at each falling edge, records the beat taken at the next rise
    always @(negedge clk) begin
        logic en;
        cyc++;
        case (en_mode)
            0:       en = 1'b0;
            1:       en = 1'b1;
            default: en = (cyc % 3 == 0);
        endcase
        out_en = en;
        if (en && out_valid) begin
            if (cfg_wide) begin
                got_q.push_back(out_data[15:8]);
                got_q.push_back(out_data[7:0]);
            end else begin
                got_q.push_back(out_data[7:0]);
                if (out_data[15:8] != 8'h00) hi_nz = 1'b1;
            end
            if (out_sol) sol_beat.push_back(beat_n);
            if (out_eol) eol_beat.push_back(beat_n);
            beat_n++;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] clipb(input logic [7:0] b);
        if (b == 8'h00) return 8'h01;
        if (b == 8'hFF) return 8'hFE;
        return b;
    endfunction

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        logic [7:0] r;
        r[7] = 1'b1; r[6] = f; r[5] = v; r[4] = h;
        r[3] = v ^ h; r[2] = f ^ h; r[1] = f ^ v; r[0] = f ^ v ^ h;
        return r;
    endfunction

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    task automatic chk_seq(input string tag);
        int idx = -1;
        for (int i = 0; i < exp_q.size() && idx < 0; i++)
            if (i >= got_q.size() || got_q[i] !== exp_q[i]) idx = i;
        if (idx < 0 && got_q.size() != exp_q.size()) idx = exp_q.size();
        if (idx < 0) chk(1'b1, tag, 0, 0);
        else if (idx >= got_q.size() || idx >= exp_q.size())
            chk(1'b0, {tag, " length"}, got_q.size(), exp_q.size());
        else
            chk(1'b0, $sformatf("%s byte %0d", tag, idx), got_q[idx], exp_q[idx]);
    endtask

    task automatic begin_test(input logic [1:0] f, input logic w, input logic e, input int m);
        @(negedge clk);
        cfg_fmt = f; cfg_wide = w; cfg_embed = e;
        got_q.delete(); exp_q.delete(); sol_beat.delete(); eol_beat.delete();
        beat_n = 0; hi_nz = 1'b0; en_mode = m;
    endtask

    task automatic send_pix(input logic [7:0] y, input logic [7:0] c, input logic s,
                            input logic e, input logic f, input logic v);
        @(negedge clk);
        in_valid = 1'b1; in_y = y; in_c = c; in_sol = s; in_eol = e;
        in_field = f; in_vblank = v;
        while (!in_req) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    endtask

    task automatic drain();
        int quiet = 0;
        while (quiet < 8) begin
            @(negedge clk);
            if (out_valid) quiet = 0; else quiet++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_req === 1'b1, "R1 in_req after reset", in_req, 1);
        chk(out_valid === 1'b0 && out_sol === 1'b0 && out_eol === 1'b0,
            "R1 outputs after reset", {out_valid, out_sol, out_eol}, 0);
    endtask

    task automatic t_422_narrow();
        begin_test(2'd0, 1'b0, 1'b0, 1);
        for (int i = 0; i < 4; i++) begin
            send_pix(8'h20 + 8'(i), 8'h80 + 8'(i), i == 0, i == 3, 1'b0, 1'b0);
            exp_q.push_back(8'h80 + 8'(i));
            exp_q.push_back(8'h20 + 8'(i));
        end
        idle_in(); drain();
        chk_seq("R2 4:2:2 byte order");
        chk(hi_nz == 1'b0, "R5 narrow high lane zero", hi_nz, 0);
        chk(sol_beat.size() == 1 && sol_beat[0] == 0, "R9 start strobe beat",
            sol_beat.size() > 0 ? sol_beat[0] : -1, 0);
        chk(eol_beat.size() == 1 && eol_beat[0] == 7, "R9 end strobe beat",
            eol_beat.size() > 0 ? eol_beat[0] : -1, 7);
    endtask

    task automatic t_411();
        begin_test(2'd1, 1'b0, 1'b0, 1);
        for (int i = 0; i < 6; i++) begin
            send_pix(8'h30 + 8'(i), 8'h90 + 8'(i), i == 0, i == 5, 1'b0, 1'b0);
            if (i % 2 == 0) exp_q.push_back(8'h90 + 8'(i));
            exp_q.push_back(8'h30 + 8'(i));
        end
        idle_in(); drain();
        chk_seq("R3 4:1:1 byte order");
    endtask

    task automatic t_y_wide();
        begin_test(2'd2, 1'b1, 1'b0, 1);
        for (int i = 0; i < 3; i++) begin
            send_pix(8'h40 + 8'(i), 8'hC0 + 8'(i), i == 0, i == 2, 1'b0, 1'b0);
            exp_q.push_back(8'h40 + 8'(i));
        end
        exp_q.push_back(8'h10);
        idle_in(); drain();
        chk_seq("R4 luma only, chroma ignored");
        chk(beat_n == 2 && got_q.size() == 4 && got_q[3] == 8'h10, "R6 odd line padded",
            beat_n, 2);
        chk(eol_beat.size() == 1 && eol_beat[0] == 1, "R9 wide end strobe",
            eol_beat.size() > 0 ? eol_beat[0] : -1, 1);
    endtask

    task automatic t_422_wide();
        begin_test(2'd0, 1'b1, 1'b0, 1);
        for (int i = 0; i < 2; i++) begin
            send_pix(8'h50 + 8'(i), 8'hA0 + 8'(i), i == 0, i == 1, 1'b0, 1'b0);
            exp_q.push_back(8'hA0 + 8'(i));
            exp_q.push_back(8'h50 + 8'(i));
        end
        idle_in(); drain();
        chk_seq("R5 wide lanes chroma high luma low");
    endtask

    task automatic t_embed();
        logic [7:0] ys[4] = '{8'h00, 8'h50, 8'hFF, 8'h60};
        logic [7:0] cs[4] = '{8'hFF, 8'h40, 8'h00, 8'h70};
        begin_test(2'd0, 1'b0, 1'b1, 1);
        for (int ln = 0; ln < 2; ln++) begin
            logic f = (ln == 0);
            logic v = (ln == 1);
            exp_q.push_back(8'hFF); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
            exp_q.push_back(xy(f, v, 1'b0));
            for (int i = 0; i < 2; i++) begin
                send_pix(ys[ln*2+i], cs[ln*2+i], i == 0, i == 1, f, v);
                exp_q.push_back(clipb(cs[ln*2+i]));
                exp_q.push_back(clipb(ys[ln*2+i]));
            end
            exp_q.push_back(8'hFF); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
            exp_q.push_back(xy(f, v, 1'b1));
        end
        idle_in(); drain();
        chk_seq("R7 embedded codes around lines");
        chk(got_q.size() > 5 && got_q[4] == 8'hFE && got_q[5] == 8'h01,
            "R8 clipping of FF and 00", got_q.size() > 5 ? {got_q[4], got_q[5]} : 0, 16'hFE01);
        chk(sol_beat.size() == 0 && eol_beat.size() == 0, "R9 strobes quiet when embedded",
            sol_beat.size() + eol_beat.size(), 0);
    endtask

    task automatic t_pass();
        begin_test(2'd0, 1'b0, 1'b0, 1);
        send_pix(8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
        send_pix(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        exp_q = '{8'hFF, 8'h00, 8'h00, 8'hFF};
        idle_in(); drain();
        chk_seq("R8 pin mode passes FF and 00");
    endtask

    task automatic t_fill();
        int acc = 0, idle = 0, guard = 0;
        begin_test(2'd0, 1'b0, 1'b0, 0);
        while (idle < 6 && guard < 400) begin
            @(negedge clk);
            guard++;
            in_valid = 1'b1; in_y = 8'(acc); in_c = 8'(acc + 100);
            in_sol = (acc == 0); in_eol = 1'b0;
            in_field = 1'b0; in_vblank = 1'b0;
            if (in_req) begin
                exp_q.push_back(8'(acc + 100));
                exp_q.push_back(8'(acc));
                acc++;
                idle = 0;
            end else idle++;
        end
        chk(acc == 64 && in_req == 1'b0, "R10 pixels accepted before request drops", acc, 64);
        chk(out_valid == 1'b1, "R11 data waits while enable low", out_valid, 1);
        in_valid = 1'b0;
        en_mode = 1;
        send_pix(8'hEE, 8'hDD, 1'b0, 1'b1, 1'b0, 1'b0);
        exp_q.push_back(8'hDD); exp_q.push_back(8'hEE);
        idle_in(); drain();
        chk_seq("R10 full buffer drains in order");
    endtask

    task automatic t_stall();
        logic [15:0] d1, d2;
        logic v1, v2;
        begin_test(2'd0, 1'b0, 1'b0, 0);
        send_pix(8'h11, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0);
        send_pix(8'h33, 8'h44, 1'b0, 1'b1, 1'b0, 1'b0);
        idle_in();
        repeat (3) @(negedge clk);
        d1 = out_data; v1 = out_valid;
        repeat (3) @(negedge clk);
        d2 = out_data; v2 = out_valid;
        chk(v1 && v2 && d1 == d2 && d1 == 16'h0022, "R11 beat held without enable", d2, 16'h0022);
        exp_q = '{8'h22, 8'h11, 8'h44, 8'h33};
        en_mode = 2;
        drain();
        chk_seq("R11 gapped reads keep order");
    endtask

    initial begin
        rst_n = 1'b0; out_en = 1'b0;
        cfg_fmt = 2'd0; cfg_wide = 1'b0; cfg_embed = 1'b0;
        in_valid = 1'b0; in_y = '0; in_c = '0; in_sol = 1'b0; in_eol = 1'b0;
        in_field = 1'b0; in_vblank = 1'b0; hi_nz = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_422_narrow();
        t_411();
        t_y_wide();
        t_422_wide();
        t_embed();
        t_pass();
        t_fill();
        t_stall();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule